// File: doc/BRIEF.md
# Buffered Crossbar Switch Core with Credit Return

This block is the core of an N×N combined input and crosspoint queued switch for packets of variable length. Every input/output pair owns a small crosspoint buffer. An input port writes the words of an arriving packet into the buffer of the output it names. It may begin a packet only when it holds enough credits for that buffer. Every output runs its own round-robin scheduler over the buffers in its column. It forwards the chosen packet by cut-through and never mixes two packets on one output.

As an output drains a buffer, it produces credit tokens for the input that filled it. These tokens go back on the link of that port number, in cycles where that link carries no data. When a token is emitted, the credit count for that crosspoint is refilled. One credit covers `CRED_WORDS` words (16 words, 64 bytes, by default). A buffer holds `XP_WORDS` words, so it has `XP_WORDS/CRED_WORDS` credits.

Each input port runs a two-state machine, `IN_IDLE` and `IN_BODY`:
- start: a start word is taken while the port is in `IN_IDLE`. The port moves to `IN_BODY` unless that word also ends the packet.
- finish: taking an end word in `IN_BODY` returns the port to `IN_IDLE`.

Each output scheduler runs a two-state machine, `OS_IDLE` and `OS_SEND`:
- grant: in `OS_IDLE`, a non-empty crosspoint in the column is picked and the scheduler moves to `OS_SEND`.
- release: forwarding the end word of the packet returns the scheduler to `OS_IDLE`. The round-robin pointer then moves to one past the input just served.

Top module: `cicq_switch`

## Requirements
- R1: After reset, no output port is valid and no credit token is sent. Every input offering a start word of a packet up to `XP_WORDS` words long sees `in_ready` high.
- R2: A start word for output d, with length L words on `in_len`, is taken only when that input holds at least ceil(L/`CRED_WORDS`) credits for crosspoint d. Otherwise `in_ready` stays low and the word is held until enough credit has come back.
- R3: While a packet is being received on an input, `in_ready` stays high for every word. Outside a packet, a word whose `in_sop` is low is refused and has no effect on any output.
- R4: Every packet appears on output `in_dest` with its words unchanged and in order. `out_sop` marks the first word and `out_eop` marks the last.
- R5: When the output is idle, the first word of a packet taken at clock edge k is presented on that output in the cycle after edge k+1. The rest follow one per cycle while the input writes one per cycle.
- R6: An idle output grants the first non-empty crosspoint at or after its pointer, counting input numbers cyclically. After each packet the pointer moves to one past the input just served.
- R7: Once an output has started a packet, it presents only words of that packet until its end word. A start word appears only as the first word of a packet.
- R8: For each 16-word (`CRED_WORDS`) run drained from crosspoint (i,d), and for the remainder at the end of the packet, exactly one token is returned to input i. It is shown as `cred_valid[i]` with `cred_xp` equal to d, and at most one token leaves a port per cycle.
- R9: A token is sent on port i only in a cycle where `out_valid[i]` is low. When several are pending, the lowest-numbered output goes first.
- R10: After traffic stops and all tokens have drained, every crosspoint again holds its full credit. A held start word is taken later and delivered intact.
- R11: Outputs schedule independently, so packets bound for different outputs are forwarded in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N | Input word valid, one bit per port |
| in_sop | input | N | Word is the first of a packet |
| in_eop | input | N | Word is the last of a packet |
| in_data | input | N*W | Input words, port p at bits p*W upward |
| in_dest | input | N*log2(N) | Output number, read with the start word |
| in_len | input | N*LW | Packet length in words, read with the start word |
| in_ready | output | N | Word on the input is taken at the next edge |
| out_valid | output | N | Output word valid |
| out_sop | output | N | Output word is the first of a packet |
| out_eop | output | N | Output word is the last of a packet |
| out_data | output | N*W | Output words |
| cred_valid | output | N | Credit token on this port's link |
| cred_xp | output | N*log2(N) | Output number of the crosspoint the token refills |

## Verification
A word taken at edge k on an idle output appears in the cycle after edge k+1. The bench samples at the falling edge, records the cycle count at acceptance and at the first output word, and requires a difference of two. Refusals are seen combinationally in the same cycle as the offered start word. Tokens are counted as they appear at any falling edge, and the totals are compared with ceil(L/16) per packet only after a long drain. The order of round-robin grants is compared as a sequence of packet sources per output, so it does not depend on the exact cycle of each grant.

// File: rtl/cicq_pkg.sv
package cicq_pkg;
    typedef enum logic {IN_IDLE, IN_BODY} in_state_e;
    typedef enum logic {OS_IDLE, OS_SEND} os_state_e;
endpackage

// File: rtl/cicq_xpoint.sv
module cicq_xpoint #(
    parameter int W     = 32,
    parameter int DEPTH = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W:0]   wr_word,
    input  logic         rd_en,
    output logic [W:0]   rd_word,
    output logic         not_empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_en) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (rd_en) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(wr_en) - CW'(rd_en);
        end
    end

    assign rd_word   = mem[rp];
    assign not_empty = (cnt != '0);
endmodule

// File: rtl/cicq_in_port.sv
module cicq_in_port
    import cicq_pkg::*;
#(
    parameter int N          = 8,
    parameter int XP_WORDS   = 32,
    parameter int CRED_WORDS = 16,
    parameter int IW         = 3,
    parameter int LW         = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_sop,
    input  logic          in_eop,
    input  logic [IW-1:0] in_dest,
    input  logic [LW-1:0] in_len,
    output logic          in_ready,
    output logic [N-1:0]  wr_en,
    input  logic [N-1:0]  tok_in,
    input  logic          link_busy,
    output logic          cred_valid,
    output logic [IW-1:0] cred_xp
);
    localparam int XPC = XP_WORDS / CRED_WORDS;
    localparam int CRW = $clog2(XPC + 1);

    in_state_e               state;
    logic [IW-1:0]           cur_dest;
    logic [N-1:0][CRW-1:0]   credit, credit_nx;
    logic [N-1:0][CRW-1:0]   pend, pend_nx;
    logic                    accept, sop_take;
    logic [IW-1:0]           tgt;
    int                      need_i;

    // output process: readiness, crosspoint write select, token pick
    always_comb begin
        need_i = (int'(in_len) + CRED_WORDS - 1) / CRED_WORDS;
        unique case (state)
            IN_IDLE: in_ready = in_sop && (int'(credit[in_dest]) >= need_i);
            IN_BODY: in_ready = 1'b1;
        endcase
        accept   = in_valid && in_ready;
        sop_take = accept && (state == IN_IDLE);
        tgt      = (state == IN_IDLE) ? in_dest : cur_dest;
        wr_en    = accept ? (N'(1) << tgt) : '0;

        cred_valid = 1'b0;
        cred_xp    = '0;
        if (!link_busy) begin
            for (int j = 0; j < N; j++) begin
                if (!cred_valid && pend[j] != '0) begin
                    cred_valid = 1'b1;
                    cred_xp    = IW'(j);
                end
            end
        end

        for (int j = 0; j < N; j++) begin
            credit_nx[j] = credit[j]
                - ((sop_take && in_dest == IW'(j)) ? CRW'(need_i) : CRW'(0))
                + ((cred_valid && cred_xp == IW'(j)) ? CRW'(1) : CRW'(0));
            pend_nx[j] = pend[j] + CRW'(tok_in[j])
                - ((cred_valid && cred_xp == IW'(j)) ? CRW'(1) : CRW'(0));
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= IN_IDLE;
            cur_dest <= '0;
        end else begin
            unique case (state)
                IN_IDLE: if (sop_take && !in_eop) begin
                    state    <= IN_BODY;
                    cur_dest <= in_dest;
                end
                IN_BODY: if (accept && in_eop) state <= IN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < N; j++) begin
                credit[j] <= CRW'(XPC);
                pend[j]   <= '0;
            end
        end else begin
            credit <= credit_nx;
            pend   <= pend_nx;
        end
    end
endmodule

// File: rtl/cicq_out_sched.sv
module cicq_out_sched
    import cicq_pkg::*;
#(
    parameter int N          = 8,
    parameter int W          = 32,
    parameter int CRED_WORDS = 16,
    parameter int IW         = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        col_ne,
    input  logic [N-1:0][W:0]   col_head,
    output logic [N-1:0]        rd_en,
    output logic                out_valid,
    output logic                out_sop,
    output logic                out_eop,
    output logic [W-1:0]        out_data,
    output logic                tok_valid,
    output logic [IW-1:0]       tok_src
);
    localparam int BW = $clog2(CRED_WORDS);

    os_state_e      state;
    logic [IW-1:0]  ptr, sel, pick;
    logic           found, first;
    logic [BW-1:0]  beat;
    logic [W:0]     head;

    // output process: round-robin pick and forwarding
    always_comb begin
        found = 1'b0;
        pick  = ptr;
        for (int k = 0; k < N; k++) begin
            if (!found && col_ne[(int'(ptr) + k) % N]) begin
                found = 1'b1;
                pick  = IW'((int'(ptr) + k) % N);
            end
        end
        head      = col_head[sel];
        out_valid = 1'b0;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        out_data  = '0;
        rd_en     = '0;
        unique case (state)
            OS_IDLE: ;
            OS_SEND: begin
                out_valid = col_ne[sel];
                out_sop   = out_valid && first;
                out_eop   = out_valid && head[W];
                out_data  = out_valid ? head[W-1:0] : '0;
                rd_en     = out_valid ? (N'(1) << sel) : '0;
            end
        endcase
        tok_valid = out_valid && (out_eop || beat == BW'(CRED_WORDS - 1));
        tok_src   = sel;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= OS_IDLE;
            ptr   <= '0;
            sel   <= '0;
            first <= 1'b0;
            beat  <= '0;
        end else begin
            unique case (state)
                OS_IDLE: if (found) begin
                    state <= OS_SEND;
                    sel   <= pick;
                    first <= 1'b1;
                    beat  <= '0;
                end
                OS_SEND: if (out_valid) begin
                    first <= 1'b0;
                    beat  <= tok_valid ? '0 : beat + 1'b1;
                    if (out_eop) begin
                        state <= OS_IDLE;
                        ptr   <= (sel == IW'(N - 1)) ? '0 : sel + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/cicq_switch.sv
module cicq_switch #(
    parameter int N          = 8,
    parameter int W          = 32,
    parameter int XP_WORDS   = 32,
    parameter int CRED_WORDS = 16,
    localparam int IW        = $clog2(N),
    localparam int LW        = $clog2(XP_WORDS + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    in_valid,
    input  logic [N-1:0]    in_sop,
    input  logic [N-1:0]    in_eop,
    input  logic [N*W-1:0]  in_data,
    input  logic [N*IW-1:0] in_dest,
    input  logic [N*LW-1:0] in_len,
    output logic [N-1:0]    in_ready,
    output logic [N-1:0]    out_valid,
    output logic [N-1:0]    out_sop,
    output logic [N-1:0]    out_eop,
    output logic [N*W-1:0]  out_data,
    output logic [N-1:0]    cred_valid,
    output logic [N*IW-1:0] cred_xp
);
    logic [N-1:0]        wr_en    [N];   // [input][output]
    logic [N-1:0]        rd_en    [N];   // [output][input]
    logic [N-1:0]        col_ne   [N];   // [output][input]
    logic [N-1:0][W:0]   col_head [N];   // [output][input]
    logic [N-1:0]        tok_to_in[N];   // [input][output]
    logic [N-1:0]        tok_valid;
    logic [IW-1:0]       tok_src  [N];

    for (genvar i = 0; i < N; i++) begin : g_in
        cicq_in_port #(
            .N(N), .XP_WORDS(XP_WORDS), .CRED_WORDS(CRED_WORDS), .IW(IW), .LW(LW)
        ) in_port_i (
            .clk        (clk),
            .rst        (rst),
            .in_valid   (in_valid[i]),
            .in_sop     (in_sop[i]),
            .in_eop     (in_eop[i]),
            .in_dest    (in_dest[i*IW +: IW]),
            .in_len     (in_len[i*LW +: LW]),
            .in_ready   (in_ready[i]),
            .wr_en      (wr_en[i]),
            .tok_in     (tok_to_in[i]),
            .link_busy  (out_valid[i]),
            .cred_valid (cred_valid[i]),
            .cred_xp    (cred_xp[i*IW +: IW])
        );
        for (genvar j = 0; j < N; j++) begin : g_xp
            assign tok_to_in[i][j] = tok_valid[j] && (tok_src[j] == IW'(i));
            cicq_xpoint #(.W(W), .DEPTH(XP_WORDS)) xp_i (
                .clk       (clk),
                .rst       (rst),
                .wr_en     (wr_en[i][j]),
                .wr_word   ({in_eop[i], in_data[i*W +: W]}),
                .rd_en     (rd_en[j][i]),
                .rd_word   (col_head[j][i]),
                .not_empty (col_ne[j][i])
            );
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_out
        cicq_out_sched #(
            .N(N), .W(W), .CRED_WORDS(CRED_WORDS), .IW(IW)
        ) out_i (
            .clk       (clk),
            .rst       (rst),
            .col_ne    (col_ne[j]),
            .col_head  (col_head[j]),
            .rd_en     (rd_en[j]),
            .out_valid (out_valid[j]),
            .out_sop   (out_sop[j]),
            .out_eop   (out_eop[j]),
            .out_data  (out_data[j*W +: W]),
            .tok_valid (tok_valid[j]),
            .tok_src   (tok_src[j])
        );
    end
endmodule

// File: rtl/cicq_switch_chk.sv
module cicq_switch_chk #(
    parameter int N          = 8,
    parameter int W          = 32,
    parameter int XP_WORDS   = 32,
    parameter int CRED_WORDS = 16,
    localparam int IW        = $clog2(N),
    localparam int LW        = $clog2(XP_WORDS + 1),
    localparam int XPC       = XP_WORDS / CRED_WORDS,
    localparam int OW        = $clog2(XPC + 1) + 1
) (
    input logic            clk,
    input logic            rst,
    input logic [N-1:0]    in_valid,
    input logic [N-1:0]    in_sop,
    input logic [N-1:0]    in_eop,
    input logic [N*LW-1:0] in_len,
    input logic [N*IW-1:0] in_dest,
    input logic [N-1:0]    in_ready,
    input logic [N-1:0]    out_valid,
    input logic [N-1:0]    out_sop,
    input logic [N-1:0]    out_eop,
    input logic [N-1:0]    cred_valid,
    input logic [N*IW-1:0] cred_xp
);
    logic [N-1:0]         in_pkt, out_pkt;
    logic [N-1:0][OW-1:0] outst [N];   // credits charged but not yet returned

    always_ff @(posedge clk) begin
        if (rst) begin
            in_pkt  <= '0;
            out_pkt <= '0;
            for (int i = 0; i < N; i++) outst[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (in_valid[i] && in_ready[i]) in_pkt[i] <= !in_eop[i];
                if (out_valid[i]) out_pkt[i] <= !out_eop[i];
                for (int j = 0; j < N; j++) begin
                    outst[i][j] <= outst[i][j]
                        + ((in_valid[i] && in_ready[i] && !in_pkt[i]
                            && in_dest[i*IW +: IW] == IW'(j))
                           ? OW'((int'(in_len[i*LW +: LW]) + CRED_WORDS - 1) / CRED_WORDS)
                           : OW'(0))
                        - ((cred_valid[i] && cred_xp[i*IW +: IW] == IW'(j)) ? OW'(1) : OW'(0));
                end
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_port
        AST_BODY_READY: assert property (@(posedge clk) disable iff (rst)
            in_pkt[g] |-> in_ready[g]); // R3
        AST_IDLE_NEEDS_SOP: assert property (@(posedge clk) disable iff (rst)
            (!in_pkt[g] && !in_sop[g]) |-> !in_ready[g]); // R3
        AST_OUT_SOP_FIRST: assert property (@(posedge clk) disable iff (rst)
            (out_valid[g] && !out_pkt[g]) |-> out_sop[g]); // R7
        AST_OUT_NO_INTERLEAVE: assert property (@(posedge clk) disable iff (rst)
            (out_valid[g] && out_pkt[g]) |-> !out_sop[g]); // R7
        AST_TOKEN_IDLE_SLOT: assert property (@(posedge clk) disable iff (rst)
            cred_valid[g] |-> !out_valid[g]); // R9
        AST_TOKEN_OWED: assert property (@(posedge clk) disable iff (rst)
            cred_valid[g] |-> (outst[g][cred_xp[g*IW +: IW]] != '0)); // R8
        for (genvar h = 0; h < N; h++) begin : g_xp
            AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (rst)
                int'(outst[g][h]) <= XPC); // R2
        end
    end
endmodule

bind cicq_switch cicq_switch_chk #(
    .N(N), .W(W), .XP_WORDS(XP_WORDS), .CRED_WORDS(CRED_WORDS)
) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_len(in_len), .in_dest(in_dest), .in_ready(in_ready), .out_valid(out_valid),
    .out_sop(out_sop), .out_eop(out_eop), .cred_valid(cred_valid), .cred_xp(cred_xp)
);

// File: tb/cicq_switch_tb.sv
module cicq_switch_tb_top;
    localparam int N  = 8;
    localparam int W  = 32;
    localparam int IW = 3;
    localparam int LW = 6;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          b_valid [N];
    logic          b_sop   [N];
    logic          b_eop   [N];
    logic [W-1:0]  b_data  [N];
    logic [IW-1:0] b_dest  [N];
    logic [LW-1:0] b_len   [N];

    logic [N-1:0]    in_valid, in_sop, in_eop, in_ready;
    logic [N*W-1:0]  in_data, out_data;
    logic [N*IW-1:0] in_dest, cred_xp;
    logic [N*LW-1:0] in_len;
    logic [N-1:0]    out_valid, out_sop, out_eop, cred_valid;

    for (genvar p = 0; p < N; p++) begin : g_drv
        assign in_valid[p]          = b_valid[p];
        assign in_sop[p]            = b_sop[p];
        assign in_eop[p]            = b_eop[p];
        assign in_data[p*W +: W]    = b_data[p];
        assign in_dest[p*IW +: IW]  = b_dest[p];
        assign in_len[p*LW +: LW]   = b_len[p];
    end

    cicq_switch dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_data(in_data), .in_dest(in_dest), .in_len(in_len), .in_ready(in_ready),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data),
        .cred_valid(cred_valid), .cred_xp(cred_xp)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic [W+1:0] expq [N][N][$];
    int ordq [N][$];
    int tok_cnt [N][N];
    int exp_tok [N][N];
    int sop_cyc [N];
    int first_cyc [N];
    int cur_src [N];
    int seq_no [N];

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mk_word(int i, int d, int s, int k);
        return {3'(i), 3'(d), 10'(s), 8'(k), 8'(i * 16 + k)};
    endfunction

    function automatic int credits_for(int len);
        return (len + CW - 1) / CW;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    task automatic send_pkt(input int i, input int d, input int len, output int waited);
        int s;
        bit body_ok;
        s = seq_no[i];
        seq_no[i]++;
        waited  = 0;
        body_ok = 1'b1;
        @(posedge clk); #1;
        b_valid[i] = 1'b1; b_sop[i] = 1'b1; b_eop[i] = (len == 1);
        b_dest[i] = IW'(d); b_len[i] = LW'(len); b_data[i] = mk_word(i, d, s, 0);
        @(negedge clk);
        while (!in_ready[i]) begin
            waited++;
            @(negedge clk);
        end
        sop_cyc[i] = cyc;
        exp_tok[i][d] += credits_for(len);
        expq[i][d].push_back({1'b1, len == 1, mk_word(i, d, s, 0)});
        for (int k = 1; k < len; k++) begin
            @(posedge clk); #1;
            b_sop[i] = 1'b0; b_eop[i] = (k == len - 1); b_data[i] = mk_word(i, d, s, k);
            @(negedge clk);
            if (!in_ready[i]) body_ok = 1'b0;
            expq[i][d].push_back({1'b0, k == len - 1, mk_word(i, d, s, k)});
        end
        if (len > 1) check(body_ok, "R3 body words always ready", body_ok, 1);
        @(posedge clk); #1;
        b_valid[i] = 1'b0; b_sop[i] = 1'b0; b_eop[i] = 1'b0;
    endtask

    // output and token monitor
    always @(negedge clk) begin
        if (!rst) begin
            for (int j = 0; j < N; j++) begin
                if (out_valid[j]) begin
                    int src;
                    logic [W+1:0] got;
                    got = {out_sop[j], out_eop[j], out_data[j*W +: W]};
                    src = int'(out_data[j*W + 29 +: 3]);
                    if (out_sop[j]) begin
                        first_cyc[j] = cyc;
                        ordq[j].push_back(src);
                        cur_src[j] = src;
                    end else begin
                        check(src == cur_src[j], "R7 no interleave", src, cur_src[j]);
                    end
                    if (expq[src][j].size() == 0) begin
                        check(1'b0, "R4 unexpected word", got, 0);
                    end else begin
                        logic [W+1:0] e;
                        e = expq[src][j].pop_front();
                        check(got == e, "R4 word content/markers", got, e);
                    end
                end
                if (cred_valid[j]) begin
                    check(!out_valid[j], "R9 token in idle slot", out_valid[j], 0);
                    tok_cnt[j][int'(cred_xp[j*IW +: IW])]++;
                end
            end
        end
    end

    task automatic run_random(input int i);
        int w;
        for (int n = 0; n < 25; n++) begin
            send_pkt(i, $urandom_range(N - 1, 0), $urandom_range(32, 1), w);
            if ($urandom_range(3, 0) == 0) repeat ($urandom_range(4, 1)) @(posedge clk);
        end
    endtask

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int w0, w1, w2;
        bit ok;
        void'($urandom(32'd20061));
        for (int p = 0; p < N; p++) begin
            b_valid[p] = 0; b_sop[p] = 0; b_eop[p] = 0;
            b_data[p] = '0; b_dest[p] = '0; b_len[p] = '0;
            seq_no[p] = 0; sop_cyc[p] = 0; first_cyc[p] = 0; cur_src[p] = 0;
            for (int q = 0; q < N; q++) begin tok_cnt[p][q] = 0; exp_tok[p][q] = 0; end
        end
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        for (int p = 0; p < N; p++) begin b_sop[p] = 1; b_len[p] = 6'd32; b_dest[p] = 3'd3; end
        @(negedge clk);
        check(out_valid == '0, "R1 outputs idle after reset", out_valid, 0);
        check(cred_valid == '0, "R1 no tokens after reset", cred_valid, 0);
        check(in_ready == '1, "R1 full credit after reset", in_ready, 8'hFF);
        for (int p = 0; p < N; p++) b_sop[p] = 0;

        // R5 latency and R11 parallel outputs
        fork
            send_pkt(0, 6, 4, w0);
            send_pkt(1, 7, 5, w1);
        join
        repeat (10) @(posedge clk);
        check(first_cyc[6] == sop_cyc[0] + 2, "R5 cut-through latency out6", first_cyc[6], sop_cyc[0] + 2);
        check(first_cyc[7] == sop_cyc[1] + 2, "R5 cut-through latency out7", first_cyc[7], sop_cyc[1] + 2);
        check(first_cyc[6] == first_cyc[7], "R11 outputs forward together", first_cyc[7], first_cyc[6]);

        // R3 non-start word outside a packet is refused and ignored
        @(posedge clk); #1;
        b_valid[2] = 1; b_sop[2] = 0; b_eop[2] = 1; b_dest[2] = 3'd5; b_len[2] = 6'd1;
        ok = 1'b1;
        repeat (3) begin @(negedge clk); if (in_ready[2]) ok = 1'b0; end
        check(ok, "R3 stray word refused", ok, 1);
        @(posedge clk); #1 b_valid[2] = 0; b_eop[2] = 0;
        ok = 1'b1;
        repeat (4) begin @(negedge clk); if (out_valid != '0) ok = 1'b0; end
        check(ok, "R3 stray word has no output effect", ok, 1);

        // R2 / R10 credit exhaustion on crosspoint (1,2)
        fork
            send_pkt(0, 2, 32, w0);
            begin
                @(posedge clk);
                send_pkt(1, 2, 32, w1);
                send_pkt(1, 2, 32, w2);
            end
        join
        check(w1 == 0, "R2 first packet admitted at once", w1, 0);
        check(w2 > 0, "R2 start held without credit", w2, 1);
        repeat (60) @(posedge clk);
        check(expq[1][2].size() == 0, "R10 held packet delivered", expq[1][2].size(), 0);

        // R6 round robin on output 4
        ordq[4].delete();
        fork
            send_pkt(7, 4, 12, w0);
            begin
                repeat (2) @(posedge clk);
                fork
                    send_pkt(1, 4, 2, w1);
                    send_pkt(3, 4, 2, w1);
                    send_pkt(5, 4, 2, w1);
                join
            end
        join
        repeat (20) @(posedge clk);
        fork
            send_pkt(6, 4, 2, w0);
            send_pkt(2, 4, 2, w1);
        join
        repeat (10) @(posedge clk);
        check(ordq[4].size() == 6, "R6 grant count", ordq[4].size(), 6);
        if (ordq[4].size() == 6) begin
            int exp_ord [6] = '{7, 1, 3, 5, 6, 2};
            for (int k = 0; k < 6; k++)
                check(ordq[4][k] == exp_ord[k], "R6 round-robin order", ordq[4][k], exp_ord[k]);
        end

        // random traffic on all inputs
        for (int i = 0; i < N; i++) begin
            fork
                automatic int ii = i;
                run_random(ii);
            join_none
        end
        wait fork;
        repeat (600) @(posedge clk);

        ok = 1'b1;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (expq[i][j].size() != 0) ok = 1'b0;
        check(ok, "R4 every packet delivered", ok, 1);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                check(tok_cnt[i][j] == exp_tok[i][j], "R8 token total per crosspoint",
                      tok_cnt[i][j], exp_tok[i][j]);
        for (int d = 0; d < N; d++) begin
            @(posedge clk); #1;
            for (int p = 0; p < N; p++) begin b_sop[p] = 1; b_len[p] = 6'd32; b_dest[p] = IW'(d); end
            @(negedge clk);
            check(in_ready == '1, "R10 full credit restored", in_ready, 8'hFF);
        end
        for (int p = 0; p < N; p++) b_sop[p] = 0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule